// File: doc/BRIEF.md
# Asynchronous External Memory Write Controller

This block is a bus master that runs single write accesses to an asynchronous external memory. It works on the clock of the memory interface. On the internal side it presents a valid/ready request port that carries an address, write data and a bank index. On the memory side it drives the address, one active-low select line per bank, an active-low write strobe, an idle read strobe and the data word with its output-enable. A memory-side ready input (ACK) can stretch the write strobe.

Each access runs through the same phases. A setup cycle places address, select and data on the bus. The write strobe then stays low for a programmed number of wait cycles, and for longer while ACK stays low. A programmed number of hold cycles keeps address, select and data valid after the strobe rises. A fixed turnaround gap follows with the data bus released. The wait and hold counts are taken from configuration inputs at the moment a request is accepted. A one-cycle done pulse marks the end of the hold phase. The controller accepts the next request only after the gap has ended.

Top module: `amem_wr_ctl`

## Requirements
- R1: While reset is asserted and directly after it, `req_ready` is 1, all bits of `mem_sel_n` are 1, `mem_wr_n` is 1, `mem_dq_oe` is 0 and `wr_done` is 0.
- R2: A request is accepted on a rising edge where `req_ready` and `req_valid` are both 1. From the next cycle until the access ends, `req_ready` is 0. Address, data and bank are captured at acceptance, and later changes to the request inputs do not affect the access. With `req_valid` low the controller stays idle.
- R3: Exactly one cycle before the write strobe falls, the bus shows the captured address and data, `mem_dq_oe` is 1, and `mem_sel_n` is all ones except bit `bank`, which is 0. At most one select bit is ever low. The strobe is low only while select and output-enable are active.
- R4: With ACK high, the write strobe stays low for Weff = max(W,1) cycles, where W is `cfg_wait`.
- R5: ACK passes through a two-stage synchronizer. If ACK is low and rises in clock cycle j of the strobe (counting from 0), the strobe stays low for max(Weff, j+3) cycles. It is never shorter than Weff.
- R6: After the strobe rises, address, data, select and output-enable stay unchanged for exactly H cycles, where H is `cfg_hold`. With H = 0 there are none.
- R7: After the hold phase come exactly two cycles with all selects high and `mem_dq_oe` 0. Only then does `req_ready` return to 1. With `req_valid` held high, the next strobe falls H+4 cycles after the previous strobe rose.
- R8: `wr_done` is high for exactly one cycle, the first cycle of the turnaround gap.
- R9: The read strobe `mem_rd_n` is always 1.
- R10: `cfg_wait` and `cfg_hold` are sampled at acceptance. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge if valid |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_bank | input | BANK_W | Bank index selecting which select line goes low |
| cfg_wait | input | WAIT_W | Wait-state count W |
| cfg_hold | input | HOLD_W | Hold-cycle count H |
| wr_done | output | 1 | One-cycle pulse when the hold phase has ended |
| mem_addr | output | ADDR_W | External address |
| mem_sel_n | output | BANKS | Active-low bank selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low read strobe, held inactive |
| mem_dq_out | output | DATA_W | Data toward the external data pads |
| mem_dq_oe | output | 1 | Output enable for the data pads |
| mem_ack | input | 1 | Memory ready, low stretches the strobe |

## Verification
Take edge A as the accepting rising edge. The setup cycle is due after edge A, and the strobe falls after edge A+1. The strobe then lasts Weff cycles, or max(Weff, j+3) cycles when ACK is raised in strobe cycle j. That figure counts two synchronizer flops and the sequencer register. Hold cycles, the two gap cycles and the done pulse follow in sequence. The bench drives inputs on falling edges and samples every output on falling edges. It counts phase lengths cycle by cycle against these expected figures, so each result is read in the cycle the registered state puts it on the pins. ACK is released at the falling edge of the chosen strobe cycle, which makes the extension deterministic.

// File: rtl/amem_wr_pkg.sv
package amem_wr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_ACKW,
      PH_HOLD,
      PH_GAP
   } phase_e;
endpackage

// File: rtl/amem_sync.sv
module amem_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("amem_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[g] <= 1'b0;
            else        sr[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[g] <= 1'b0;
            else        sr[g] <= sr[g-1];
         end
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/amem_wr_seq.sv
module amem_wr_seq
   import amem_wr_pkg::*;
#(
   parameter int WAIT_W   = 4,
   parameter int HOLD_W   = 3,
   parameter int TURN_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              ack_s,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic [HOLD_W-1:0] cfg_hold,
   output phase_e            phase,
   output logic              accept,
   output logic              done
);
   localparam int TURN_W = $clog2(TURN_CYC) + 1;
   localparam int WH_W   = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;
   localparam int CNT_W  = (WH_W > TURN_W) ? WH_W : TURN_W;
   localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

   if (TURN_CYC < 2) begin : g_bad_turn
      $error("amem_wr_seq: TURN_CYC must be at least 2");
   end

   phase_e            ph_q, ph_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [WAIT_W-1:0] wait_q;
   logic [HOLD_W-1:0] hold_q;
   logic              done_q, done_d;
   logic              leave;

   assign accept = (ph_q == PH_IDLE) && req_valid;
   assign phase  = ph_q;
   assign done   = done_q;

   always_comb begin
      ph_d   = ph_q;
      cnt_d  = cnt_q;
      done_d = 1'b0;
      leave  = 1'b0;
      case (ph_q)
         PH_IDLE:   if (req_valid) ph_d = PH_SETUP;
         PH_SETUP: begin
            ph_d  = PH_STROBE;
            cnt_d = (wait_q == '0) ? '0 : CNT_W'(wait_q - WAIT_W'(1));
         end
         PH_STROBE: begin
            if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
            else if (ack_s)   leave = 1'b1;
            else              ph_d  = PH_ACKW;
         end
         PH_ACKW:   if (ack_s) leave = 1'b1;
         PH_HOLD: begin
            if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
            else begin
               ph_d   = PH_GAP;
               cnt_d  = TURN_LAST;
               done_d = 1'b1;
            end
         end
         PH_GAP: begin
            if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
            else             ph_d  = PH_IDLE;
         end
         default:   ph_d = PH_IDLE;
      endcase
      if (leave) begin
         if (hold_q != '0) begin
            ph_d  = PH_HOLD;
            cnt_d = CNT_W'(hold_q - HOLD_W'(1));
         end else begin
            ph_d   = PH_GAP;
            cnt_d  = TURN_LAST;
            done_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         wait_q <= '0;
         hold_q <= '0;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         done_q <= done_d;
         if (accept) begin
            wait_q <= cfg_wait;
            hold_q <= cfg_hold;
         end
      end
   end
endmodule

// File: rtl/amem_wr_drv.sv
module amem_wr_drv
   import amem_wr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int BANKS  = 4,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  phase_e            phase,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [BANK_W-1:0] req_bank,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BANKS-1:0]  mem_sel_n,
   output logic              mem_wr_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [BANK_W-1:0] bank_q;
   logic              bus_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         bank_q <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_data;
         bank_q <= req_bank;
      end
   end

   assign bus_on     = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                       (phase == PH_ACKW)  || (phase == PH_HOLD);
   assign mem_wr_n   = !((phase == PH_STROBE) || (phase == PH_ACKW));
   assign mem_dq_oe  = bus_on;
   assign mem_addr   = addr_q;
   assign mem_dq_out = data_q;

   if (BANKS == 1) begin : g_single
      logic unused_bank;
      assign unused_bank = ^bank_q;
      assign mem_sel_n   = !bus_on;
   end else begin : g_multi
      assign mem_sel_n = bus_on ? ~(BANKS'(1) << bank_q) : '1;
   end
endmodule

// File: rtl/amem_wr_ctl.sv
module amem_wr_ctl #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int BANKS       = 4,
   parameter int WAIT_W      = 4,
   parameter int HOLD_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int TURN_CYC    = 2,
   localparam int BANK_W     = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic [HOLD_W-1:0] cfg_hold,
   output logic              wr_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BANKS-1:0]  mem_sel_n,
   output logic              mem_wr_n,
   output logic              mem_rd_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic              mem_ack
);
   import amem_wr_pkg::*;

   if (ADDR_W < 1 || DATA_W < 1 || BANKS < 1 || WAIT_W < 1 || HOLD_W < 1) begin : g_bad_width
      $error("amem_wr_ctl: widths and bank count must be positive");
   end

   phase_e phase;
   logic   accept;
   logic   ack_s;

   amem_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mem_ack),
      .q     (ack_s)
   );

   amem_wr_seq #(
      .WAIT_W   (WAIT_W),
      .HOLD_W   (HOLD_W),
      .TURN_CYC (TURN_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .ack_s     (ack_s),
      .cfg_wait  (cfg_wait),
      .cfg_hold  (cfg_hold),
      .phase     (phase),
      .accept    (accept),
      .done      (wr_done)
   );

   amem_wr_drv #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BANKS  (BANKS),
      .BANK_W (BANK_W)
   ) u_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .phase      (phase),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .req_bank   (req_bank),
      .mem_addr   (mem_addr),
      .mem_sel_n  (mem_sel_n),
      .mem_wr_n   (mem_wr_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

   assign req_ready = (phase == PH_IDLE);
   assign mem_rd_n  = 1'b1;
endmodule

// File: rtl/amem_wr_chk.sv
module amem_wr_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int BANKS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              wr_done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [BANKS-1:0]  mem_sel_n,
   input logic              mem_wr_n,
   input logic              mem_rd_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&mem_sel_n && mem_wr_n && !mem_dq_oe)); // R7

   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_sel_n)); // R3

   AST_STROBE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> (mem_dq_oe && !(&mem_sel_n))); // R3

   AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr_n) |-> $past(mem_dq_oe && !(&mem_sel_n))); // R3

   AST_RD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_n); // R9

   AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (!mem_dq_oe && &mem_sel_n && !req_ready)); // R8

   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> ($past(!mem_dq_oe) && $past(!mem_dq_oe, 2))); // R7

   AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_sel_n) && $past(!(&mem_sel_n))) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R6
endmodule

bind amem_wr_ctl amem_wr_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .BANKS  (BANKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .wr_done    (wr_done),
   .mem_addr   (mem_addr),
   .mem_sel_n  (mem_sel_n),
   .mem_wr_n   (mem_wr_n),
   .mem_rd_n   (mem_rd_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/amem_wr_ctl_bench.sv
`timescale 1ns/1ps
module amem_wr_ctl_bench;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int NB = 4;
   localparam int BW = 2;
   localparam int WW = 4;
   localparam int HW = 3;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [BW-1:0] bank;
      logic [WW-1:0] wt;
      logic [HW-1:0] hd;
   } vec_t;

   localparam vec_t TBL [6] = '{
      '{16'h1234, 16'hA5A5, 2'd0, 4'd3,  3'd2},
      '{16'h0001, 16'h5A5A, 2'd1, 4'd0,  3'd0},
      '{16'hBEEF, 16'h0F0F, 2'd2, 4'd1,  3'd4},
      '{16'hFFFF, 16'hF00D, 2'd3, 4'd5,  3'd0},
      '{16'h8000, 16'h1111, 2'd1, 4'd2,  3'd1},
      '{16'h4242, 16'hFFFF, 2'd2, 4'd15, 3'd7}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [BW-1:0] req_bank = '0;
   logic [WW-1:0] cfg_wait = '0;
   logic [HW-1:0] cfg_hold = '0;
   logic          wr_done;
   logic [AW-1:0] mem_addr;
   logic [NB-1:0] mem_sel_n;
   logic          mem_wr_n;
   logic          mem_rd_n;
   logic [DW-1:0] mem_dq_out;
   logic          mem_dq_oe;
   logic          mem_ack = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   int rd_bad = 0;

   always #10 clk = ~clk;

   amem_wr_ctl u_amem_wr_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .req_bank   (req_bank),
      .cfg_wait   (cfg_wait),
      .cfg_hold   (cfg_hold),
      .wr_done    (wr_done),
      .mem_addr   (mem_addr),
      .mem_sel_n  (mem_sel_n),
      .mem_wr_n   (mem_wr_n),
      .mem_rd_n   (mem_rd_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .mem_ack    (mem_ack)
   );

   always @(negedge clk) if (rst_n && mem_rd_n !== 1'b1) rd_bad++;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
      end
   endtask

   task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [BW-1:0] b, input logic [WW-1:0] w,
                            input logic [HW-1:0] h, input int ackj, input bit disturb);
      int weff, exp_low, n_low, n_hold, n_gap, n_done, f_bad;
      logic [NB-1:0] esel;
      weff    = (w == 0) ? 1 : int'(w);
      exp_low = (ackj < 0) ? weff : ((ackj + 3 > weff) ? ackj + 3 : weff);
      esel    = ~(NB'(1) << b);
      f_bad   = 0;
      @(negedge clk);
      req_addr = a; req_data = d; req_bank = b;
      cfg_wait = w; cfg_hold = h; req_valid = 1'b1;
      if (ackj >= 0) mem_ack = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (disturb) begin
         cfg_wait = w + 4'd7; cfg_hold = h + 3'd3;
         req_addr = ~a; req_data = ~d; req_bank = b + 2'd1;
      end
      chk(req_ready == 1'b0 && mem_wr_n == 1'b1, "R2 busy in setup cycle", req_ready, 0);
      chk(mem_sel_n == esel && mem_dq_oe && mem_addr == a && mem_dq_out == d,
          "R3 setup cycle bus", mem_sel_n, esel);
      @(negedge clk);
      n_low = 0;
      while (mem_wr_n == 1'b0 && n_low < 64) begin
         n_low++;
         if (mem_sel_n != esel || !mem_dq_oe || mem_addr != a || mem_dq_out != d) f_bad++;
         if (ackj >= 0 && n_low == ackj + 1) mem_ack = 1'b1;
         @(negedge clk);
      end
      if (ackj < 0) chk(n_low == exp_low, disturb ? "R10 strobe width" : "R4 strobe width", n_low, exp_low);
      else          chk(n_low == exp_low, "R5 ack stretched width", n_low, exp_low);
      n_hold = 0;
      while (mem_wr_n == 1'b1 && mem_sel_n == esel && n_hold < 64) begin
         n_hold++;
         if (!mem_dq_oe || mem_addr != a || mem_dq_out != d) f_bad++;
         @(negedge clk);
      end
      chk(n_hold == int'(h), disturb ? "R10 hold cycles" : "R6 hold cycles", n_hold, h);
      n_gap = 0; n_done = 0;
      while (!req_ready && n_gap < 64) begin
         n_gap++;
         if (wr_done) n_done += (n_gap == 1) ? 1 : 10;
         if (mem_sel_n != '1 || mem_dq_oe) f_bad++;
         @(negedge clk);
      end
      chk(n_gap == 2, "R7 turnaround gap", n_gap, 2);
      chk(n_done == 1, "R8 done pulse", n_done, 1);
      chk(f_bad == 0, "R6 fields held and released", f_bad, 0);
      mem_ack = 1'b1;
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL R2 watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int hi_cnt, guard;
      bit seen_ready;
      repeat (3) @(negedge clk);
      chk(req_ready && mem_sel_n == '1 && mem_wr_n && !mem_dq_oe && !wr_done,
          "R1 outputs in reset", {req_ready, mem_wr_n, mem_dq_oe}, 3'b110);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(req_ready && mem_sel_n == '1 && mem_wr_n && !mem_dq_oe && !wr_done,
          "R1 R2 idle after reset", {req_ready, mem_wr_n, mem_dq_oe}, 3'b110);

      for (int i = 0; i < 6; i++)
         run_write(TBL[i].addr, TBL[i].data, TBL[i].bank, TBL[i].wt, TBL[i].hd, -1, 1'b0);

      run_write(16'h0A0A, 16'h3C3C, 2'd1, 4'd2, 3'd1, 3, 1'b0);
      run_write(16'h0B0B, 16'hC3C3, 2'd3, 4'd6, 3'd0, 1, 1'b0);
      run_write(16'h0C0C, 16'h7777, 2'd0, 4'd0, 3'd2, 0, 1'b0);
      run_write(16'h5555, 16'h9999, 2'd2, 4'd3, 3'd2, -1, 1'b1);

      // R2 R7: valid held high, next strobe spacing
      @(negedge clk);
      req_addr = 16'h2222; req_data = 16'h3333; req_bank = 2'd0;
      cfg_wait = 4'd1; cfg_hold = 3'd2; req_valid = 1'b1;
      guard = 0;
      while (mem_wr_n && guard < 64) begin guard++; @(negedge clk); end
      while (!mem_wr_n && guard < 64) begin guard++; @(negedge clk); end
      hi_cnt = 0; seen_ready = 1'b0;
      while (mem_wr_n && hi_cnt < 64) begin
         hi_cnt++;
         if (req_ready) seen_ready = 1'b1;
         @(negedge clk);
      end
      chk(hi_cnt == 2 + 4, "R7 strobe spacing with valid held", hi_cnt, 6);
      chk(seen_ready, "R2 ready returns between accesses", seen_ready, 1);
      req_valid = 1'b0;
      guard = 0;
      while (!req_ready && guard < 64) begin guard++; @(negedge clk); end
      repeat (3) @(negedge clk);
      chk(req_ready && mem_sel_n == '1, "R2 stays idle without valid", req_ready, 1);
      chk(rd_bad == 0, "R9 read strobe inactive", rd_bad, 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule